// File: doc/BRIEF.md
# Low-Power Stop Mode Sequencer

This block decides the power mode of a small processor subsystem. It watches a wait-for-interrupt request from the core and two configuration bits: a deep-sleep select and a sleep-on-exit flag. With deep-sleep clear, it parks the core in SLEEP, where only the core clock is stopped. With deep-sleep set, it heads for STOP. On the way it lingers in STOP_PENDING until flash programming and any peripheral bus transfer have finished. Once in STOP it gates the whole core-domain clock, switches off the high-speed oscillator and the PLL, and drives a regulator low-power request from a configuration bit.

An interrupt in STOP moves the block to WAKE. There the high-speed oscillator is restarted alone, and the clocks stay gated until the oscillator reports ready. The number of cycles spent in WAKE is published as a latency figure. An interrupt during STOP_PENDING cancels the entry. When sleep-on-exit is armed, each return from an interrupt handler drops the core back into SLEEP. A watchdog-running latch can be set by a key write or by a hardware option, and only reset clears it. The low-speed oscillators and the real-time clock follow their own enables in every mode.

Named transitions:
- RUN→SLEEP on a light wait request, or on a handler return while sleep-on-exit is armed.
- SLEEP→RUN on an interrupt.
- RUN→STOP_PENDING on a deep wait request.
- STOP_PENDING→RUN on an interrupt, which cancels the entry.
- STOP_PENDING→STOP when both busy flags are low.
- STOP→WAKE on an interrupt.
- WAKE→RUN when the oscillator is ready.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, `state_o` is RUN. State codes are RUN=0, SLEEP=1, STOP_PENDING=2, STOP=3, WAKE=4. After reset, `cpu_clk_en`, `dom_clk_en`, `hso_en` and `pll_en` are 1, while `reg_lp_req`, `wdg_run` and `wake_lat` are 0.
- R2: In RUN, a `wfi_req` with `cfg_deep`=0 moves the block to SLEEP at the next edge. SLEEP has `cpu_clk_en`=0 and `dom_clk_en`=1. An `irq` in SLEEP returns the block to RUN at the next edge.
- R3: A light `wfi_req` arms sleep-on-exit with the value of `cfg_sleep_on_exit`, and a deep one disarms it. While armed, an `irq_ret` pulse in RUN moves the block to SLEEP at the next edge. While disarmed, `irq_ret` leaves the block in RUN.
- R4: In RUN, a `wfi_req` with `cfg_deep`=1 moves the block to STOP_PENDING. The block stays there while `nvm_busy` or `bus_busy` is 1, and all clock and oscillator enables remain 1.
- R5: The block moves from STOP_PENDING to STOP at the first edge where `nvm_busy` and `bus_busy` are both sampled 0.
- R6: In STOP, `cpu_clk_en`, `dom_clk_en`, `hso_en` and `pll_en` are all 0.
- R7: `reg_lp_req` equals `cfg_reg_lp` while in STOP and is 0 in every other state.
- R8: An `irq` in STOP moves the block to WAKE. WAKE has `hso_en`=1 and `pll_en`=0, with both clock enables 0. The block moves to RUN at the edge where `hso_ready` is sampled 1.
- R9: On leaving WAKE, `wake_lat` is loaded with the number of clock edges spent in WAKE, counting the exit edge. The value saturates at 2^LAT_W-1 and holds until the next wakeup.
- R10: An `irq` in STOP_PENDING returns the block to RUN at the next edge. This takes priority over the busy flags clearing.
- R11: `wdg_run` becomes 1 after a `wdg_key` pulse or while `wdg_hw_opt` is 1. It then stays 1 through every mode until reset.
- R12: `lsi_run`, `lse_run` and `rtc_run` follow `lsi_en`, `lse_en` and `rtc_en` in every state, including STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_req | input | 1 | Wait-for-interrupt pulse from the core |
| irq | input | 1 | Wakeup interrupt pending |
| irq_ret | input | 1 | Pulse marking an interrupt handler return |
| cfg_deep | input | 1 | Deep-sleep select (1 = stop) |
| cfg_sleep_on_exit | input | 1 | Sleep-on-exit select |
| cfg_reg_lp | input | 1 | Regulator low-power select for stop |
| nvm_busy | input | 1 | Flash programming in progress |
| bus_busy | input | 1 | Peripheral bus transfer in progress |
| hso_ready | input | 1 | High-speed oscillator ready |
| wdg_key | input | 1 | Watchdog start key write pulse |
| wdg_hw_opt | input | 1 | Watchdog hardware-start option |
| lsi_en | input | 1 | Low-speed internal oscillator enable |
| lse_en | input | 1 | Low-speed external oscillator enable |
| rtc_en | input | 1 | Real-time clock enable |
| state_o | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | Core clock enable |
| dom_clk_en | output | 1 | Core-domain clock enable |
| hso_en | output | 1 | High-speed oscillators enable |
| pll_en | output | 1 | PLL enable |
| reg_lp_req | output | 1 | Regulator low-power request |
| wdg_run | output | 1 | Watchdog running latch |
| lsi_run | output | 1 | Low-speed internal oscillator running |
| lse_run | output | 1 | Low-speed external oscillator running |
| rtc_run | output | 1 | Real-time clock running |
| wake_lat | output | LAT_W | Cycles spent in the last wakeup |

## Verification
The main sequencing is tried with several kinds of wait request: light, light with sleep-on-exit, and deep. This separates the SLEEP path from the STOP path, and an armed handler return from a disarmed one. Deep entries are made under several busy patterns: flash only, bus only, both clearing at different times, and none. These show that STOP is reached only on the first edge with both flags clear. An interrupt arrives during the pending wait to prove it cancels the entry even when the busy flags clear at the same time. Wakeups are run with oscillator-ready delays of zero, a few, and more cycles than the counter can hold, which checks the exact latency count, its saturation, and that the clocks stay gated until ready.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_SLEEP    = 3'd1,
        ST_STOP_PND = 3'd2,
        ST_STOP     = 3'd3,
        ST_WAKE     = 3'd4
    } pwr_state_e;
endpackage

// File: rtl/pwr_wdg_latch.sv
module pwr_wdg_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic key_start,
    input  logic hw_start,
    output logic running
);
    // Sticky: only the asynchronous reset clears it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            running <= 1'b0;
        else if (key_start || hw_start)
            running <= 1'b1;
    end
endmodule

// File: rtl/pwr_wake_counter.sv
module pwr_wake_counter #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_wake,
    input  logic             done,
    output logic [LAT_W-1:0] lat
);
    localparam logic [LAT_W-1:0] LAT_MAX = {LAT_W{1'b1}};

    logic [LAT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lat   <= '0;
        end else begin
            if (!in_wake)
                cnt_q <= '0;
            else if (cnt_q != LAT_MAX)
                cnt_q <= cnt_q + 1'b1;
            if (in_wake && done)
                lat <= (cnt_q == LAT_MAX) ? LAT_MAX : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_pkg::*;
#(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wfi_req,
    input  logic             irq,
    input  logic             irq_ret,
    input  logic             cfg_deep,
    input  logic             cfg_sleep_on_exit,
    input  logic             cfg_reg_lp,
    input  logic             nvm_busy,
    input  logic             bus_busy,
    input  logic             hso_ready,
    input  logic             wdg_key,
    input  logic             wdg_hw_opt,
    input  logic             lsi_en,
    input  logic             lse_en,
    input  logic             rtc_en,
    output logic [2:0]       state_o,
    output logic             cpu_clk_en,
    output logic             dom_clk_en,
    output logic             hso_en,
    output logic             pll_en,
    output logic             reg_lp_req,
    output logic             wdg_run,
    output logic             lsi_run,
    output logic             lse_run,
    output logic             rtc_run,
    output logic [LAT_W-1:0] wake_lat
);
    pwr_state_e state_q, state_d;
    logic       soe_arm_q;
    logic       busy_any;

    assign busy_any = nvm_busy | bus_busy;

    // State register and sleep-on-exit arm flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            soe_arm_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && wfi_req)
                soe_arm_q <= ~cfg_deep & cfg_sleep_on_exit;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (wfi_req)
                    state_d = cfg_deep ? ST_STOP_PND : ST_SLEEP;
                else if (irq_ret && soe_arm_q)
                    state_d = ST_SLEEP;
            end
            ST_SLEEP:    if (irq) state_d = ST_RUN;
            ST_STOP_PND: begin
                if (irq)
                    state_d = ST_RUN;
                else if (!busy_any)
                    state_d = ST_STOP;
            end
            ST_STOP:     if (irq) state_d = ST_WAKE;
            ST_WAKE:     if (hso_ready) state_d = ST_RUN;
            default:     state_d = ST_RUN;
        endcase
    end

    // Outputs decoded from the current state
    always_comb begin
        cpu_clk_en = 1'b1;
        dom_clk_en = 1'b1;
        hso_en     = 1'b1;
        pll_en     = 1'b1;
        reg_lp_req = 1'b0;
        unique case (state_q)
            ST_RUN, ST_STOP_PND: ;
            ST_SLEEP: cpu_clk_en = 1'b0;
            ST_STOP: begin
                cpu_clk_en = 1'b0;
                dom_clk_en = 1'b0;
                hso_en     = 1'b0;
                pll_en     = 1'b0;
                reg_lp_req = cfg_reg_lp;
            end
            ST_WAKE: begin
                cpu_clk_en = 1'b0;
                dom_clk_en = 1'b0;
                pll_en     = 1'b0;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;
    assign lsi_run = lsi_en;
    assign lse_run = lse_en;
    assign rtc_run = rtc_en;

    pwr_wdg_latch u_wdg (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_start (wdg_key),
        .hw_start  (wdg_hw_opt),
        .running   (wdg_run)
    );

    pwr_wake_counter #(.LAT_W(LAT_W)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_wake (state_q == ST_WAKE),
        .done    (hso_ready),
        .lat     (wake_lat)
    );
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] state,
    input logic       irq,
    input logic       nvm_busy,
    input logic       bus_busy,
    input logic       hso_ready,
    input logic       cfg_reg_lp,
    input logic       cpu_clk_en,
    input logic       dom_clk_en,
    input logic       hso_en,
    input logic       pll_en,
    input logic       reg_lp_req,
    input logic       wdg_run
);
    localparam logic [2:0] C_RUN = 3'd0, C_PND = 3'd2, C_STOP = 3'd3;

    p_stop_after_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == C_STOP) |-> $past(!nvm_busy && !bus_busy));

    p_stop_all_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == C_STOP) |-> (!cpu_clk_en && !dom_clk_en && !hso_en && !pll_en));

    p_reg_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != C_STOP) |-> !reg_lp_req);

    p_ungate_on_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_clk_en) |-> $past(hso_ready));

    p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == C_PND && irq) |=> (state == C_RUN));

    p_wdg_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_run |=> wdg_run);

    p_lp_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == C_STOP) |-> (reg_lp_req == cfg_reg_lp));
endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state_o),
    .irq        (irq),
    .nvm_busy   (nvm_busy),
    .bus_busy   (bus_busy),
    .hso_ready  (hso_ready),
    .cfg_reg_lp (cfg_reg_lp),
    .cpu_clk_en (cpu_clk_en),
    .dom_clk_en (dom_clk_en),
    .hso_en     (hso_en),
    .pll_en     (pll_en),
    .reg_lp_req (reg_lp_req),
    .wdg_run    (wdg_run)
);

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;
    localparam int LAT_W = 8;
    localparam logic [2:0] S_RUN = 3'd0, S_SLP = 3'd1, S_PND = 3'd2, S_STP = 3'd3, S_WK = 3'd4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wfi_req = 0, irq = 0, irq_ret = 0, cfg_deep = 0, cfg_sleep_on_exit = 0, cfg_reg_lp = 0;
    logic nvm_busy = 0, bus_busy = 0, hso_ready = 0, wdg_key = 0, wdg_hw_opt = 0;
    logic lsi_en = 0, lse_en = 0, rtc_en = 0;
    logic [2:0] state_o;
    logic cpu_clk_en, dom_clk_en, hso_en, pll_en, reg_lp_req, wdg_run, lsi_run, lse_run, rtc_run;
    logic [LAT_W-1:0] wake_lat;

    int n_vec = 0, n_bad = 0;

    always #5 clk = ~clk;

    pwr_mode_seq #(.LAT_W(LAT_W)) u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(); @(posedge clk); @(negedge clk); endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic do_reset();
        rst_n = 0; tick(); tick(); rst_n = 1; tick();
    endtask

    task automatic wfi(input logic deep, input logic soe);
        cfg_deep = deep; cfg_sleep_on_exit = soe; wfi_req = 1; tick(); wfi_req = 0;
    endtask

    task automatic t_reset();
        chk("R1 state", state_o, S_RUN);
        chk("R1 clocks", {cpu_clk_en, dom_clk_en, hso_en, pll_en}, 4'hF);
        chk("R1 reg_lp", reg_lp_req, 0);
        chk("R1 wdg", wdg_run, 0);
        chk("R1 lat", wake_lat, 0);
    endtask

    task automatic t_sleep();
        wfi(0, 0);
        chk("R2 sleep", state_o, S_SLP);
        chk("R2 clocks", {cpu_clk_en, dom_clk_en}, 2'b01);
        tick(); chk("R2 hold", state_o, S_SLP);
        irq = 1; tick(); irq = 0;
        chk("R2 wake", state_o, S_RUN);
    endtask

    task automatic t_soe();
        wfi(0, 1); chk("R3 sleep", state_o, S_SLP);
        irq = 1; tick(); irq = 0; chk("R3 run", state_o, S_RUN);
        tick(); chk("R3 handler", state_o, S_RUN);
        irq_ret = 1; tick(); irq_ret = 0; chk("R3 reenter", state_o, S_SLP);
        irq = 1; tick(); irq = 0;
        irq_ret = 1; tick(); irq_ret = 0; chk("R3 reenter2", state_o, S_SLP);
        irq = 1; tick(); irq = 0;
        wfi(0, 0); irq = 1; tick(); irq = 0;
        irq_ret = 1; tick(); irq_ret = 0; chk("R3 disarmed", state_o, S_RUN);
    endtask

    task automatic t_stop_wait();
        nvm_busy = 1; bus_busy = 0;
        wfi(1, 0); chk("R4 pending", state_o, S_PND);
        chk("R4 clocks on", {cpu_clk_en, dom_clk_en, hso_en, pll_en}, 4'hF);
        tick(); tick(); chk("R4 hold nvm", state_o, S_PND);
        nvm_busy = 0; bus_busy = 1; tick(); chk("R4 hold bus", state_o, S_PND);
        bus_busy = 0; tick(); chk("R5 enter", state_o, S_STP);
    endtask

    task automatic t_stop_outputs(input logic lp);
        cfg_reg_lp = lp; #1;
        chk("R6 off", {cpu_clk_en, dom_clk_en, hso_en, pll_en}, 4'h0);
        chk("R7 reg", reg_lp_req, lp);
    endtask

    task automatic t_wake(input int n_low, input int exp_lat);
        hso_ready = 0; irq = 1; tick(); irq = 0;
        chk("R8 wake", state_o, S_WK);
        chk("R8 osc first", {hso_en, pll_en, dom_clk_en, cpu_clk_en}, 4'b1000);
        chk("R7 off in wake", reg_lp_req, 0);
        for (int i = 0; i < n_low; i++) tick();
        chk("R8 gated", {state_o, dom_clk_en}, {S_WK, 1'b0});
        hso_ready = 1; tick(); hso_ready = 0;
        chk("R8 run", state_o, S_RUN);
        chk("R9 latency", wake_lat, exp_lat);
    endtask

    task automatic to_stop();
        wfi(1, 0); tick(); chk("R5 direct", state_o, S_STP);
    endtask

    task automatic t_cancel();
        nvm_busy = 1; wfi(1, 0);
        irq = 1; nvm_busy = 0; tick(); irq = 0;
        chk("R10 cancel", state_o, S_RUN);
        tick(); chk("R10 stays run", state_o, S_RUN);
    endtask

    task automatic t_wdg_lowspeed();
        lsi_en = 1; lse_en = 0; rtc_en = 1;
        wdg_key = 1; tick(); wdg_key = 0;
        chk("R11 key", wdg_run, 1);
        to_stop();
        chk("R12 lowspeed", {lsi_run, lse_run, rtc_run}, 3'b101);
        lsi_en = 0; lse_en = 1; #1;
        chk("R12 follow", {lsi_run, lse_run, rtc_run}, 3'b011);
        t_wake(0, 1);
        chk("R11 sticky", wdg_run, 1);
        do_reset(); chk("R11 reset clears", wdg_run, 0);
        wdg_hw_opt = 1; tick(); wdg_hw_opt = 0; tick();
        chk("R11 hw opt", wdg_run, 1);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        t_reset();
        t_sleep();
        t_soe();
        t_stop_wait();
        t_stop_outputs(1);
        t_stop_outputs(0);
        t_wake(0, 1);
        to_stop(); t_wake(4, 5);
        to_stop(); t_wake(300, 255);
        t_cancel();
        t_wdg_lowspeed();
        finish_run();
    end
endmodule